// File: doc/BRIEF.md
# Host Protected Area Lock Controller

This block guards the setting that caps the highest host-visible LBA of a disk and so hides a protected area above it. A command decoder in front of it hands over one request per pulse of `cmd_valid`. That request is either a cap update or a security subcommand. A security subcommand is selected by the value on `features` and can load a password, lock, unlock or freeze. The controller answers each request exactly one cycle later with a completion pulse. When the request is refused, an abort flag is raised alongside that pulse.

A 32-byte password guards the lock. A wrong password on an unlock attempt costs one try from a small budget, and an empty budget refuses every later unlock. Freezing refuses every request until power returns.

Password, lock, freeze, try budget and the memory of which addressing form created the area survive the hard and soft reset input. Power-on reset clears them. A cap written with the keep option is also copied to the persistent value, which the surrounding storage logic holds across power loss. That persistent value is reloaded from `boot_max` at power-on and is restored into the live cap on a hard reset. The true capacity of the medium is always reported on its own port.

Top module: `hpa_lock_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, the block loads `max_lba` and `persist_max` from `boot_max`, clears the password to all zeros, clears `locked` and `frozen`, sets `tries_left` to 5, forgets any earlier protected area, and holds `rsp_done` low.
- R2: A request sampled with `cmd_valid` high (and `hard_rst` low) produces `rsp_done` high in the following cycle only. `rsp_abort` is high in that same cycle exactly when the request is refused. `rsp_abort` is never high without `rsp_done`.
- R3: With `cmd_sub`=1, the value on `features` selects the subcommand: 8'h01 loads the password, 8'h02 locks, 8'h03 unlocks and 8'h04 freezes. Any other value is refused, and no state changes.
- R4: A password load stores `pw_in` unless the block is locked, in which case the load is refused and the stored password is kept.
- R5: A lock sets `locked`. While `locked` is 1, a cap update is refused and `max_lba` does not change.
- R6: An unlock whose `pw_in` equals the stored password completes and clears `locked`. The stored password is unchanged afterwards.
- R7: An unlock with a wrong password is refused and decrements `tries_left` by one. When `tries_left` is 0, every unlock is refused, even one with the correct password, and `tries_left` stays at 0.
- R8: After a freeze completes, `frozen` is 1 and every request of either kind is refused, with no state change, until power-on reset.
- R9: With `cmd_sub`=0, `features` is ignored. `new_max` is accepted into `max_lba` unless it exceeds the native maximum.
- R10: An accepted cap update with `opt_keep`=1 also writes `persist_max`. With `opt_keep`=0, `persist_max` is left alone. A pulse on `hard_rst` restores `max_lba` from `persist_max`.
- R11: A cap update with `opt_keep`=1 is refused while `offset_mode` is 1. With `opt_keep`=0 the same update is allowed.
- R12: Once a cap update has been accepted with one addressing form (`cmd_ext`=0 for 28-bit, 1 for 48-bit), a cap update that uses the other form is refused until power-on reset.
- R13: A pulse on `hard_rst` changes none of the following: password, `locked`, `frozen`, `tries_left` and the remembered addressing form. A request presented in the same cycle as `hard_rst` gets no response.
- R14: `native_max` always shows the parameter NATIVE_MAX, whatever the current cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| hard_rst | input | 1 | Hard or soft reset pulse, active high, synchronous |
| boot_max | input | LBA_W | Persistent cap as read back at power-on |
| offset_mode | input | 1 | Address offset mode is active |
| cmd_valid | input | 1 | Request strobe, one cycle |
| cmd_sub | input | 1 | 1: security subcommand, 0: cap update |
| cmd_ext | input | 1 | Cap update uses the 48-bit form |
| features | input | 8 | Subcommand selector |
| opt_keep | input | 1 | Cap update also becomes persistent |
| new_max | input | LBA_W | Requested cap |
| pw_in | input | PW_BYTES*8 | Supplied password |
| rsp_done | output | 1 | Request finished |
| rsp_abort | output | 1 | Request refused (with rsp_done) |
| max_lba | output | LBA_W | Current cap |
| persist_max | output | LBA_W | Value to hold across power loss |
| native_max | output | LBA_W | True medium capacity |
| locked | output | 1 | Lock is in force |
| frozen | output | 1 | All requests are refused |
| tries_left | output | CNT_W | Remaining unlock attempts |

## Verification
Directed sequences walk through the specific orders that separate the state rules:
- a lock followed by an unlock with the same password, then a relock and another unlock, shows that the password is kept;
- a run of wrong unlocks drains the budget, after which the correct password must still be refused;
- a freeze followed by a hard reset shows that hard reset does not release the freeze;
- plain-then-extended cap updates exercise the addressing-form check;
- keep versus volatile writes around a hard reset tell the persistent path from the live one.

After these, several hundred random requests mix subcommand values, including invalid ones, passwords from a small pool, caps around the native limit, both addressing forms, the offset flag, and occasional hard and power-on resets. This random traffic exposes interactions between lock, budget and freeze that the directed steps do not order.

// File: rtl/hpa_lock_ctrl.sv
module hpa_lock_ctrl #(
  parameter int LBA_W = 48,
  parameter int PW_BYTES = 32,
  parameter int TRIES = 5,
  parameter logic [63:0] NATIVE_MAX = 64'h0000_0000_000F_FFFF,
  localparam int PW_W = PW_BYTES * 8,
  localparam int CNT_W = $clog2(TRIES + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             hard_rst,
  input  logic [LBA_W-1:0] boot_max,
  input  logic             offset_mode,
  input  logic             cmd_valid,
  input  logic             cmd_sub,
  input  logic             cmd_ext,
  input  logic [7:0]       features,
  input  logic             opt_keep,
  input  logic [LBA_W-1:0] new_max,
  input  logic [PW_W-1:0]  pw_in,
  output logic             rsp_done,
  output logic             rsp_abort,
  output logic [LBA_W-1:0] max_lba,
  output logic [LBA_W-1:0] persist_max,
  output logic [LBA_W-1:0] native_max,
  output logic             locked,
  output logic             frozen,
  output logic [CNT_W-1:0] tries_left
);
  localparam logic [LBA_W-1:0] NAT = NATIVE_MAX[LBA_W-1:0];
  localparam logic [CNT_W-1:0] TRY_INIT = CNT_W'(TRIES);
  localparam logic [7:0] SUB_PW = 8'h01, SUB_LOCK = 8'h02, SUB_OPEN = 8'h03, SUB_FREEZE = 8'h04;

  logic [PW_W-1:0] pw_q;
  logic            area_set, area_ext;
  logic            reject;

  wire pw_match = (pw_in == pw_q);
  wire is_open  = cmd_sub && (features == SUB_OPEN);
  wire take     = cmd_valid && !hard_rst;

  assign native_max = NAT;

  always_comb begin
    reject = 1'b0;
    if (frozen) reject = 1'b1;
    else if (cmd_sub) begin
      case (features)
        SUB_PW:     reject = locked;
        SUB_LOCK:   reject = 1'b0;
        SUB_OPEN:   reject = (tries_left == '0) || !pw_match;
        SUB_FREEZE: reject = 1'b0;
        default:    reject = 1'b1;
      endcase
    end else begin
      reject = locked || (new_max > NAT) || (opt_keep && offset_mode)
               || (area_set && (area_ext != cmd_ext));
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pw_q        <= '0;
      locked      <= 1'b0;
      frozen      <= 1'b0;
      tries_left  <= TRY_INIT;
      area_set    <= 1'b0;
      area_ext    <= 1'b0;
      max_lba     <= boot_max;
      persist_max <= boot_max;
      rsp_done    <= 1'b0;
      rsp_abort   <= 1'b0;
    end else if (hard_rst) begin
      max_lba   <= persist_max;
      rsp_done  <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_done  <= cmd_valid;
      rsp_abort <= cmd_valid && reject;
      if (cmd_valid && is_open && !frozen && tries_left != '0 && !pw_match)
        tries_left <= tries_left - 1'b1;
      if (cmd_valid && !reject) begin
        if (cmd_sub) begin
          case (features)
            SUB_PW:     pw_q   <= pw_in;
            SUB_LOCK:   locked <= 1'b1;
            SUB_OPEN:   locked <= 1'b0;
            SUB_FREEZE: frozen <= 1'b1;
            default:    ;
          endcase
        end else begin
          max_lba  <= new_max;
          area_set <= 1'b1;
          area_ext <= cmd_ext;
          if (opt_keep) persist_max <= new_max;
        end
      end
    end
  end

  // R2
  abort_needs_done_chk: assert property (@(posedge clk) disable iff (!por_n)
    rsp_abort |-> rsp_done);

  // R2
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    take |=> rsp_done);

  // R5
  locked_cap_refused_chk: assert property (@(posedge clk) disable iff (!por_n)
    (take && !cmd_sub && locked) |=> (rsp_abort && $stable(max_lba)));

  // R7
  tries_never_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    (tries_left <= TRY_INIT) |=> (tries_left <= $past(tries_left)));

  // R8
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    frozen |=> frozen);

  // R8
  frozen_refuses_chk: assert property (@(posedge clk) disable iff (!por_n)
    (frozen && take) |=> rsp_abort);

  // R13
  hard_rst_keeps_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_rst |=> ($stable(locked) && $stable(frozen) && $stable(tries_left) && !rsp_done));
endmodule

// File: tb/hpa_lock_ctrl_test.sv
`timescale 1ns/1ps
module hpa_lock_ctrl_test;
  localparam int LBA_W = 48;
  localparam int PW_W = 256;
  localparam logic [LBA_W-1:0] NAT = 48'h0F_FFFF;

  logic clk = 0, por_n = 0, hard_rst = 0, offset_mode = 0;
  logic cmd_valid = 0, cmd_sub = 0, cmd_ext = 0, opt_keep = 0;
  logic [7:0] features = 0;
  logic [LBA_W-1:0] boot_max = NAT, new_max = 0;
  logic [PW_W-1:0] pw_in = 0;
  logic rsp_done, rsp_abort, locked, frozen;
  logic [LBA_W-1:0] max_lba, persist_max, native_max;
  logic [2:0] tries_left;

  hpa_lock_ctrl uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errs = 0;
  logic [PW_W-1:0] m_pw, pool [4];
  bit m_locked, m_frozen, m_set, m_ext;
  int m_tries;
  logic [LBA_W-1:0] m_max, m_persist;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic bit exp_rej(bit sub, bit ext, bit keep, logic [7:0] f,
                                 logic [LBA_W-1:0] nm, logic [PW_W-1:0] pw);
    if (m_frozen) return 1;
    if (sub) begin
      case (f)
        8'h01: return m_locked;
        8'h02, 8'h04: return 0;
        8'h03: return (m_tries == 0) || (pw != m_pw);
        default: return 1;
      endcase
    end
    return m_locked || (nm > NAT) || (keep && offset_mode) || (m_set && (m_ext != ext));
  endfunction

  task automatic check_state(string tag);
    chk(tag, "max_lba", 64'(max_lba), 64'(m_max));
    chk(tag, "persist_max", 64'(persist_max), 64'(m_persist));
    chk(tag, "locked", 64'(locked), 64'(m_locked));
    chk(tag, "frozen", 64'(frozen), 64'(m_frozen));
    chk(tag, "tries_left", 64'(tries_left), 64'(m_tries));
    chk("R14", "native_max", 64'(native_max), 64'(NAT));
  endtask

  task automatic power_on(logic [LBA_W-1:0] bm);
    @(negedge clk);
    por_n = 0; boot_max = bm;
    repeat (2) @(negedge clk);
    por_n = 1;
    m_pw = '0; m_locked = 0; m_frozen = 0; m_set = 0; m_ext = 0;
    m_tries = 5; m_max = bm; m_persist = bm;
    chk("R1", "rsp_done", 64'(rsp_done), 0);
    check_state("R1");
  endtask

  task automatic do_hard(string tag);
    @(negedge clk);
    hard_rst = 1; cmd_valid = 1; cmd_sub = 1; features = 8'h04;
    @(negedge clk);
    hard_rst = 0; cmd_valid = 0;
    m_max = m_persist;
    chk("R13", "no response during hard reset", 64'(rsp_done), 0);
    check_state(tag);
  endtask

  task automatic req(string tag, bit sub, bit ext, bit keep, logic [7:0] f,
                     logic [LBA_W-1:0] nm, logic [PW_W-1:0] pw);
    bit rej;
    @(negedge clk);
    cmd_valid = 1; cmd_sub = sub; cmd_ext = ext; opt_keep = keep;
    features = f; new_max = nm; pw_in = pw;
    rej = exp_rej(sub, ext, keep, f, nm, pw);
    @(negedge clk);
    cmd_valid = 0;
    chk("R2", "rsp_done", 64'(rsp_done), 1);
    chk(tag, "rsp_abort", 64'(rsp_abort), 64'(rej));
    if (sub && f == 8'h03 && !m_frozen && m_tries != 0 && pw != m_pw) m_tries--;
    if (!rej) begin
      if (sub) begin
        case (f)
          8'h01: m_pw = pw;
          8'h02: m_locked = 1;
          8'h03: m_locked = 0;
          8'h04: m_frozen = 1;
          default: ;
        endcase
      end else begin
        m_max = nm; m_set = 1; m_ext = ext;
        if (keep) m_persist = nm;
      end
    end
    check_state(tag);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL R2 watchdog: got still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++)
      for (int w = 0; w < 8; w++) pool[i][w*32 +: 32] = (i == 0) ? 32'd0 : $urandom;

    power_on(NAT);
    req("R9", 0, 0, 0, 8'h55, 48'h0F_0000, '0);
    do_hard("R10");
    req("R10", 0, 0, 1, 8'h00, 48'h0F_C000, '0);
    @(negedge clk);
    chk("R2", "done is one cycle", 64'(rsp_done), 0);
    req("R12", 0, 1, 0, 8'h00, 48'h0F_8000, '0);
    req("R9", 0, 0, 0, 8'h00, NAT + 1, '0);
    req("R9", 0, 0, 0, 8'h00, NAT, '0);
    offset_mode = 1;
    req("R11", 0, 0, 1, 8'h00, 48'h0F_0000, '0);
    req("R11", 0, 0, 0, 8'h00, 48'h0F_0000, '0);
    offset_mode = 0;
    req("R3", 1, 0, 0, 8'h05, 0, pool[1]);
    req("R3", 1, 0, 0, 8'h00, 0, pool[1]);
    req("R4", 1, 0, 0, 8'h01, 0, pool[1]);
    req("R5", 1, 0, 0, 8'h02, 0, '0);
    req("R5", 0, 0, 0, 8'h00, 48'h01_0000, '0);
    req("R4", 1, 0, 0, 8'h01, 0, pool[2]);
    req("R7", 1, 0, 0, 8'h03, 0, pool[2]);
    req("R6", 1, 0, 0, 8'h03, 0, pool[1]);
    req("R5", 1, 0, 0, 8'h02, 0, '0);
    req("R6", 1, 0, 0, 8'h03, 0, pool[1]);
    req("R5", 1, 0, 0, 8'h02, 0, '0);
    do_hard("R13");
    for (int k = 0; k < 4; k++) req("R7", 1, 0, 0, 8'h03, 0, pool[3]);
    req("R7", 1, 0, 0, 8'h03, 0, pool[1]);
    req("R7", 1, 0, 0, 8'h03, 0, pool[3]);
    power_on(48'h0F_C000);
    req("R13", 1, 0, 0, 8'h03, 0, '0);
    req("R12", 0, 1, 0, 8'h00, 48'h0F_0000, '0);
    req("R12", 0, 0, 0, 8'h00, 48'h0F_1000, '0);
    req("R8", 1, 0, 0, 8'h04, 0, '0);
    req("R8", 1, 0, 0, 8'h01, 0, pool[2]);
    req("R8", 0, 1, 0, 8'h00, 48'h0E_0000, '0);
    req("R8", 1, 0, 0, 8'h03, 0, '0);
    req("R8", 1, 0, 0, 8'h04, 0, '0);
    do_hard("R8");
    req("R8", 1, 0, 0, 8'h02, 0, '0);
    power_on(NAT);

    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) power_on(48'(($urandom_range(0, 3) == 0) ? NAT : 48'h0F_0000));
      else if (r < 6) do_hard("R13");
      else begin
        bit sub = $urandom_range(0, 1);
        logic [7:0] f = 8'($urandom_range(0, 5));
        logic [LBA_W-1:0] nm = NAT - 48'($urandom_range(0, 40)) + 48'($urandom_range(0, 2));
        offset_mode = ($urandom_range(0, 4) == 0);
        req(sub ? (f == 8'h03 ? "R7" : "R3") : "R9", sub, $urandom_range(0, 7) == 0,
            $urandom_range(0, 1), f, nm, pool[$urandom_range(0, 3)]);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule